// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block sends frames that software has queued in a ring of transmit buffer descriptors. The descriptors sit in a word-addressed memory, and each one is two 32-bit words. The first word is the byte address of a buffer. The second word carries ownership, ring-closing and frame-end flags and the byte count of that buffer.

After software pulses the start command, the fetcher reads descriptors one after another and streams the bytes of each buffer to a byte-wide output marked with valid and last. A frame may span several buffers, and it ends with the buffer whose last flag is set. When a frame is complete, the fetcher hands the frame's first descriptor back to software by setting its used bit in memory, then raises a sticky completion flag and an interrupt. It keeps walking the ring and stops at the first descriptor that software still owns. The ring closes where a descriptor carries the wrap flag, not at a fixed depth.

Memory reads have a fixed latency of one cycle: read data is valid in the cycle after the request. The ring base is a word address that software loads. Dropping the transmit enable aborts any activity and rewinds the ring pointer to that base.

Top module: `tx_desc_fetch`

## Requirements
- R1: During and after reset, `tx_valid_o`, `tx_last_o`, `status_o`, `irq_o` and `mem_req_o` are all 0.
- R2: A start pulse is acted on only while `tx_en_i` is 1. A start pulse given while the enable is 0 causes no memory access, no output bytes and no status change.
- R3: Word 0 of a descriptor is the buffer byte address, and its two low bits are ignored. Word 1 holds the flags: bit 31 is used, bit 30 is wrap, bit 15 is last buffer, and bits 10:0 are the byte count (1 to 2047). The bytes of a buffer come out in ascending address order, which within each memory word means bits 7:0 first.
- R4: `tx_last_o` is 1 only together with the final byte of a buffer that has the last flag set. A frame continues across buffers until such a buffer is reached.
- R5: If a descriptor read at the start of a frame has used=1, no bytes are sent, `status_o[0]` (used-bit read) is set and fetching stops. The pointer stays on that descriptor, so the next start resumes there.
- R6: If a descriptor with used=1 is read in the middle of a frame, `status_o[1]` (buffers exhausted) is set and fetching stops. No `tx_last_o` is produced for that frame, completion is not raised and nothing is written back.
- R7: After the last byte of a frame, the status word of the frame's first descriptor is rewritten with bit 31 set and its other bits unchanged. No other descriptor of that frame is written. Then `status_o[2]` (complete) and `irq_o` are set.
- R8: After a descriptor with wrap=1, the next descriptor is read at the ring base. Otherwise the next descriptor is read two words further on. A ring of a single descriptor with wrap set works.
- R9: After a frame, the fetcher goes on to the following descriptors without a new start pulse, until it meets a used one.
- R10: While `tx_en_i` is 0, no memory request is made, and `tx_valid_o` is 0 from the following cycle. Re-enabling makes the next start read from the ring base.
- R11: The status flags and `irq_o` stay set until a 1 is written to the matching bit of `status_clr_i` or to `irq_clr_i`. Clearing one flag leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable; low aborts and rewinds to the ring base |
| tx_start_i | input | 1 | Start-transmit pulse |
| ring_base_i | input | MAW | Word address of descriptor 0 |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write (write-back) when 1, read when 0 |
| mem_addr_o | output | MAW | Word address of the access |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read request |
| tx_data_o | output | 8 | Frame byte |
| tx_valid_o | output | 1 | Byte valid |
| tx_last_o | output | 1 | Final byte of a frame |
| status_clr_i | input | 3 | Write-one-to-clear for status_o |
| irq_clr_i | input | 1 | Write-one-to-clear for irq_o |
| status_o | output | 3 | Bit 0 used-bit read, bit 1 buffers exhausted, bit 2 complete |
| irq_o | output | 1 | Transmit-complete interrupt |

## Verification
The hardest conditions to create from the ports are the pointer resting on a descriptor that the fetcher itself handed back, and a ring that wraps in the middle of a run. The stimulus builds a three-descriptor ring in which the second frame wraps onto the already written-back first descriptor. It then releases only that descriptor and restarts, which shows that fetching resumes where it stopped. A further case lets the buffers run out mid-frame and then re-enables, to show that the pointer rewinds to the base. Randomized rings of one to four descriptors, with random buffer counts, last flags and unaligned address bits, are compared byte by byte and descriptor by descriptor against values the bench computes.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;
  localparam int USED_BIT = 31;
  localparam int WRAP_BIT = 30;
  localparam int LAST_BIT = 15;
  localparam int CNT_W    = 11;

  localparam int FL_UBR  = 0;
  localparam int FL_BEX  = 1;
  localparam int FL_COMP = 2;
  localparam int FL_IRQ  = 3;
  localparam int N_FLAGS = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_A, S_RD_S, S_DEC, S_RD_W, S_CAP, S_EMIT, S_NEXT, S_WB
  } fetch_st_t;
endpackage

// File: rtl/tx_ring_ptr.sv
module tx_ring_ptr #(
  parameter int MAW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [MAW-1:0] base_i,
  input  logic           hold_base_i,
  input  logic           adv_i,
  input  logic           wrap_i,
  output logic [MAW-1:0] ptr_o
);
  localparam logic [MAW-1:0] DESC_STEP = MAW'(2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ptr_o <= '0;
    else if (hold_base_i) ptr_o <= base_i;
    else if (adv_i)       ptr_o <= wrap_i ? base_i : ptr_o + DESC_STEP;
  end
endmodule

// File: rtl/tx_stat_flags.sv
module tx_stat_flags #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_byte_out.sv
module tx_byte_out (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        flush_i,
  input  logic        emit_i,
  input  logic [31:0] word_i,
  input  logic [1:0]  sel_i,
  input  logic        last_i,
  output logic [7:0]  data_o,
  output logic        valid_o,
  output logic        last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end else begin
      valid_o <= emit_i && !flush_i;
      last_o  <= emit_i && !flush_i && last_i;
      if (emit_i) data_o <= word_i[8*sel_i +: 8];
    end
  end

  a_r4_last_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);
  a_r4_gap_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !valid_o);
  a_r10_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !valid_o);
endmodule

// File: rtl/tx_desc_fetch.sv
module tx_desc_fetch
  import tx_ring_pkg::*;
#(
  parameter int MAW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tx_en_i,
  input  logic           tx_start_i,
  input  logic [MAW-1:0] ring_base_i,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [MAW-1:0] mem_addr_o,
  output logic [31:0]    mem_wdata_o,
  input  logic [31:0]    mem_rdata_i,
  output logic [7:0]     tx_data_o,
  output logic           tx_valid_o,
  output logic           tx_last_o,
  input  logic [2:0]     status_clr_i,
  input  logic           irq_clr_i,
  output logic [2:0]     status_o,
  output logic           irq_o
);
  localparam logic [MAW-1:0] ONE_W = MAW'(1);

  fetch_st_t        st_q;
  logic [MAW-1:0]   ptr, first_ptr_q, wptr_q, baddr_q;
  logic [31:0]      first_stat_q, word_q;
  logic [CNT_W-1:0] rem_q;
  logic [1:0]       bsel_q;
  logic             last_q, wrap_q, frame_q;
  logic [N_FLAGS-1:0] fset, fclr, fq;
  logic             in_dec_used, emit, adv;

  assign in_dec_used = tx_en_i && (st_q == S_DEC) && mem_rdata_i[USED_BIT];
  assign emit        = tx_en_i && (st_q == S_EMIT);
  assign adv         = tx_en_i && (st_q == S_NEXT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= S_IDLE;
      first_ptr_q  <= '0;
      first_stat_q <= '0;
      wptr_q       <= '0;
      baddr_q      <= '0;
      word_q       <= '0;
      rem_q        <= '0;
      bsel_q       <= '0;
      last_q       <= 1'b0;
      wrap_q       <= 1'b0;
      frame_q      <= 1'b0;
    end else if (!tx_en_i) begin
      st_q    <= S_IDLE;
      frame_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (tx_start_i) st_q <= S_RD_A;
        S_RD_A: st_q <= S_RD_S;
        S_RD_S: begin
          baddr_q <= mem_rdata_i[MAW+1:2];
          st_q    <= S_DEC;
        end
        S_DEC: begin
          if (mem_rdata_i[USED_BIT]) begin
            frame_q <= 1'b0;
            st_q    <= S_IDLE;
          end else begin
            if (!frame_q) begin
              first_ptr_q  <= ptr;
              first_stat_q <= mem_rdata_i;
            end
            rem_q  <= mem_rdata_i[CNT_W-1:0];
            last_q <= mem_rdata_i[LAST_BIT];
            wrap_q <= mem_rdata_i[WRAP_BIT];
            wptr_q <= baddr_q;
            bsel_q <= '0;
            st_q   <= (mem_rdata_i[CNT_W-1:0] == '0) ? S_NEXT : S_RD_W;
          end
        end
        S_RD_W: st_q <= S_CAP;
        S_CAP: begin
          word_q <= mem_rdata_i;
          wptr_q <= wptr_q + ONE_W;
          st_q   <= S_EMIT;
        end
        S_EMIT: begin
          rem_q  <= rem_q - CNT_W'(1);
          bsel_q <= bsel_q + 2'd1;
          if (rem_q == CNT_W'(1))  st_q <= S_NEXT;
          else if (bsel_q == 2'd3) st_q <= S_RD_W;
        end
        S_NEXT: begin
          frame_q <= !last_q;
          st_q    <= last_q ? S_WB : S_RD_A;
        end
        S_WB:    st_q <= S_RD_A;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st_q)
      S_RD_S:  mem_addr_o = ptr + ONE_W;
      S_RD_W:  mem_addr_o = wptr_q;
      S_WB:    mem_addr_o = first_ptr_q + ONE_W;
      default: mem_addr_o = ptr;
    endcase
  end

  assign mem_req_o   = tx_en_i && (st_q == S_RD_A || st_q == S_RD_S ||
                                   st_q == S_RD_W || st_q == S_WB);
  assign mem_we_o    = tx_en_i && (st_q == S_WB);
  assign mem_wdata_o = first_stat_q | (32'h1 << USED_BIT);

  always_comb begin
    fset          = '0;
    fset[FL_UBR]  = in_dec_used && !frame_q;
    fset[FL_BEX]  = in_dec_used && frame_q;
    fset[FL_COMP] = mem_we_o;
    fset[FL_IRQ]  = mem_we_o;
  end
  assign fclr = {irq_clr_i, status_clr_i};

  tx_ring_ptr #(.MAW(MAW)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .base_i     (ring_base_i),
    .hold_base_i(!tx_en_i),
    .adv_i      (adv),
    .wrap_i     (wrap_q),
    .ptr_o      (ptr)
  );

  tx_stat_flags #(.N(N_FLAGS)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (fset),
    .clr_i (fclr),
    .q_o   (fq)
  );

  tx_byte_out u_bytes (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(!tx_en_i),
    .emit_i (emit),
    .word_i (word_q),
    .sel_i  (bsel_q),
    .last_i (last_q && (rem_q == CNT_W'(1))),
    .data_o (tx_data_o),
    .valid_o(tx_valid_o),
    .last_o (tx_last_o)
  );

  assign status_o = fq[FL_COMP:FL_UBR];
  assign irq_o    = fq[FL_IRQ];

  a_r7_comp_after_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[2]) |-> $past(mem_we_o));
  a_r5_stop_is_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[0]) |-> (!tx_valid_o && !mem_req_o));
  a_r6_bex_no_comp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[1]) |-> !$past(mem_we_o));
endmodule

// File: tb/sim_tx_desc_fetch.sv
`timescale 1ns/1ps
module sim_tx_desc_fetch;
  localparam int MAW = 8;
  localparam logic [31:0] U = 32'h8000_0000, W = 32'h4000_0000, L = 32'h0000_8000;

  logic clk_i = 0, rst_ni = 0, tx_en_i = 0, tx_start_i = 0, irq_clr_i = 0;
  logic [MAW-1:0] ring_base_i = '0;
  logic [2:0] status_clr_i = '0;
  logic mem_req_o, mem_we_o, tx_valid_o, tx_last_o, irq_o;
  logic [MAW-1:0] mem_addr_o;
  logic [31:0] mem_wdata_o, mem_rdata_i;
  logic [7:0] tx_data_o;
  logic [2:0] status_o;

  always #10 clk_i = ~clk_i;

  tx_desc_fetch #(.MAW(MAW)) u0 (.*);

  logic [31:0] mem [256];
  logic [31:0] shadow [256];
  logic tb_we = 0;
  logic [7:0] tb_addr = 0;
  logic [31:0] tb_data = 0;
  always @(posedge clk_i) begin
    if (tb_we) mem[tb_addr] <= tb_data;
    else if (mem_req_o) begin
      if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
      else mem_rdata_i <= mem[mem_addr_o];
    end
  end

  logic [7:0] cap_d[$];
  logic cap_l[$];
  int req_cnt = 0;
  always @(negedge clk_i) if (rst_ni) begin
    if (tx_valid_o) begin cap_d.push_back(tx_data_o); cap_l.push_back(tx_last_o); end
    if (mem_req_o) req_cnt++;
  end

  logic [7:0] exp_d[$];
  logic exp_l[$];
  int n_chk = 0, n_err = 0, base_idx = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [31:0] d);
    tb_addr = a; tb_data = d; tb_we = 1; shadow[a] = d;
    @(negedge clk_i); tb_we = 0;
  endtask

  task automatic fill_buf(input int w, input int n);
    for (int i = 0; i < (n + 3) / 4; i++) poke(8'(w + i), $urandom);
  endtask

  task automatic add_buf(input int w, input int n, input bit last);
    for (int k = 0; k < n; k++) begin
      exp_d.push_back(shadow[w + k / 4][8 * (k % 4) +: 8]);
      exp_l.push_back(last && (k == n - 1));
    end
  endtask

  task automatic set_desc(input int dw, input int bw, input logic [1:0] lo, input logic [31:0] st);
    poke(8'(dw), {22'd0, 8'(bw), lo});
    poke(8'(dw + 1), st);
  endtask

  task automatic restart_ring(input int b);
    tx_en_i = 0; ring_base_i = 8'(b);
    @(negedge clk_i); tx_en_i = 1;
    @(negedge clk_i);
  endtask

  task automatic run();
    int t;
    base_idx = cap_d.size();
    status_clr_i = 3'b111; irq_clr_i = 1; @(negedge clk_i);
    status_clr_i = 0; irq_clr_i = 0;
    tx_start_i = 1; @(negedge clk_i); tx_start_i = 0;
    t = 0;
    while (!(status_o[0] | status_o[1]) && t < 4000) begin @(negedge clk_i); t++; end
    repeat (4) @(negedge clk_i);
  endtask

  task automatic cmp(input string req);
    int mism = 0;
    chk({req, " byte count"}, cap_d.size() - base_idx, exp_d.size());
    for (int i = 0; i < exp_d.size(); i++)
      if (base_idx + i < cap_d.size())
        if (cap_d[base_idx + i] !== exp_d[i] || cap_l[base_idx + i] !== exp_l[i]) mism++;
    chk({req, " byte/last mismatches"}, mism, 0);
    exp_d.delete(); exp_l.delete();
  endtask

  initial begin
    repeat (200000) @(negedge clk_i);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int r, l0, l1, l2, n, mism;
    logic [31:0] s0, s1, s2;
    logic [31:0] st[4];
    bit first[4];
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin mem[i] = 0; shadow[i] = 0; end
    repeat (2) @(negedge clk_i);
    chk("R1 valid in reset", tx_valid_o, 0);
    chk("R1 req in reset", mem_req_o, 0);
    rst_ni = 1; @(negedge clk_i);
    chk("R1 valid", tx_valid_o, 0);
    chk("R1 last", tx_last_o, 0);
    chk("R1 status", status_o, 0);
    chk("R1 irq", irq_o, 0);

    // R2: start ignored while disabled
    r = req_cnt; base_idx = cap_d.size();
    tx_start_i = 1; @(negedge clk_i); tx_start_i = 0;
    repeat (20) @(negedge clk_i);
    chk("R2 no bytes", cap_d.size() - base_idx, 0);
    chk("R2 no memory access", req_cnt - r, 0);
    chk("R2 status", status_o, 0);

    // R3 R4 R7 R8: ring of one, unaligned address bits
    fill_buf('h40, 5);
    s0 = W | L | 32'd5;
    set_desc('h10, 'h40, 2'b11, s0);
    add_buf('h40, 5, 1);
    restart_ring('h10);
    run();
    cmp("R3 R4 single buffer");
    chk("R7 complete", status_o[2], 1);
    chk("R7 irq", irq_o, 1);
    chk("R8 ring of one stops on same descriptor", status_o[0], 1);
    chk("R6 no exhaust", status_o[1], 0);
    chk("R7 write-back", mem['h11], s0 | U);

    // R11 write-one-to-clear
    status_clr_i = 3'b100; @(negedge clk_i); status_clr_i = 0; @(negedge clk_i);
    chk("R11 clear complete only", status_o, 3'b001);
    chk("R11 irq kept", irq_o, 1);
    irq_clr_i = 1; @(negedge clk_i); irq_clr_i = 0; @(negedge clk_i);
    chk("R11 irq cleared", irq_o, 0);
    chk("R11 status kept", status_o, 3'b001);

    // R4 R7 R8 R9: three descriptors, two frames, wrap onto written-back descriptor
    l0 = 1 + $urandom % 12; l1 = 1 + $urandom % 12; l2 = 1 + $urandom % 12;
    fill_buf('h40, l0); fill_buf('h48, l1); fill_buf('h50, l2);
    s0 = 32'(l0); s1 = L | 32'(l1); s2 = W | L | 32'(l2);
    set_desc('h20, 'h40, 2'b00, s0);
    set_desc('h22, 'h48, 2'b01, s1);
    set_desc('h24, 'h50, 2'b10, s2);
    add_buf('h40, l0, 0); add_buf('h48, l1, 1); add_buf('h50, l2, 1);
    restart_ring('h20);
    run();
    cmp("R4 R9 two frames");
    chk("R7 first descriptor written back", mem['h21], s0 | U);
    chk("R7 second descriptor untouched", mem['h23], s1);
    chk("R7 third descriptor written back", mem['h25], s2 | U);
    chk("R8 wrap stop used-read", status_o[0], 1);
    chk("R7 complete after frames", status_o[2], 1);

    // R5: resume on the descriptor where it stopped
    s0 = L | 32'(l0);
    poke('h21, s0);
    add_buf('h40, l0, 1); add_buf('h48, l1, 1);
    run();
    cmp("R5 resume at stopped descriptor");
    chk("R5 later descriptor written back", mem['h23], s1 | U);

    // R6: buffers exhausted mid-frame
    fill_buf('h60, 6); fill_buf('h68, 3);
    set_desc('h30, 'h60, 2'b00, 32'd6);
    set_desc('h32, 'h68, 2'b00, U | L | 32'd3);
    add_buf('h60, 6, 0);
    restart_ring('h30);
    run();
    cmp("R6 partial frame");
    chk("R6 exhausted", status_o[1], 1);
    chk("R6 no complete", status_o[2], 0);
    chk("R6 no used-read", status_o[0], 0);
    chk("R6 no irq", irq_o, 0);
    chk("R6 no write-back", mem['h31], 32'd6);

    // R10: re-enable rewinds pointer to base
    poke('h33, W | L | 32'd3);
    add_buf('h60, 6, 0); add_buf('h68, 3, 1);
    restart_ring('h30);
    run();
    cmp("R10 rewind to base");
    chk("R10 write-back of first", mem['h31], 32'd6 | U);

    // R10: abort of a long frame
    fill_buf('h80, 200);
    set_desc('h30, 'h80, 2'b00, W | L | 32'd200);
    restart_ring('h30);
    base_idx = cap_d.size();
    status_clr_i = 3'b111; irq_clr_i = 1; @(negedge clk_i);
    status_clr_i = 0; irq_clr_i = 0;
    tx_start_i = 1; @(negedge clk_i); tx_start_i = 0;
    repeat (40) @(negedge clk_i);
    tx_en_i = 0; @(negedge clk_i);
    chk("R10 valid low after disable", tx_valid_o, 0);
    r = req_cnt;
    repeat (10) @(negedge clk_i);
    chk("R10 no memory access while off", req_cnt - r, 0);
    chk("R10 frame cut short", (cap_d.size() - base_idx) < 200, 1);
    chk("R10 no complete", status_o[2], 0);
    chk("R10 no write-back", mem['h31], W | L | 32'd200);

    // random rings
    for (int it = 0; it < 4; it++) begin
      n = 1 + $urandom % 4;
      for (int i = 0; i < n; i++) begin
        l0 = 1 + $urandom % 16;
        first[i] = (i == 0) || st[i-1][15];
        st[i] = 32'(l0) | ((i == n - 1) ? (W | L) : (($urandom % 2) ? L : 32'd0));
        fill_buf('h40 + 8 * i, l0);
        set_desc('h10 + 2 * i, 'h40 + 8 * i, 2'($urandom), st[i]);
        add_buf('h40 + 8 * i, l0, st[i][15]);
      end
      restart_ring('h10);
      run();
      cmp("R9 random ring");
      chk("R7 random complete", status_o[2], 1);
      chk("R8 random wrap stop", status_o[0], 1);
      mism = 0;
      for (int i = 0; i < n; i++)
        if (mem['h11 + 2 * i] !== (st[i] | (first[i] ? U : 32'd0))) mism++;
      chk("R7 random write-back pattern", mism, 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule